// File: doc/BRIEF.md
# Multichannel TDM Audio Serial Transmitter

This block is the transmit half of a time-division-multiplexed audio serial port. It runs from a high-frequency master clock. From that clock it derives a bit clock and a frame sync of its own. A host hands it one 32-bit sample at a time for each of several serial data pins. Every pin shares the same bit clock, frame sync and slot sequence, and each pin carries its own sample stream. The block is typically wired to a group of converters that all run from one bit clock and one frame sync, with one data line per converter.

A frame holds a programmable number of 32-bit slots, from 2 to 32. A long-frame mode uses 384 slots instead. A 32-bit enable mask can switch off any slot, and the pins stay low while it runs. A one-master-cycle event marks the start of the last slot in each frame. The frame sync can be one bit wide or one slot wide, and either polarity can be chosen for it and for the bit clock. Each pin holds one pending sample. If that sample is missing when an enabled slot starts, the block sends zeros and raises a sticky underrun flag.

Configuration inputs must stay constant while `enable` is high. Lowering `enable` returns the bit clock, frame sync and shift logic to idle. It does not clear samples already written, and it does not clear the underrun flag.

Top module: `tdm_audio_tx`

## Requirements
- R1: After reset with `enable` low, `bclk` equals `cfg_bclk_inv`, `fsync` equals `cfg_fs_inv`, and `sdata`, `last_slot` and `underrun` are all 0.
- R2: With `cfg_div` = D and F = D+1 (so D from 0 to 4095 gives F from 1 to 4096), each half period of the bit clock lasts F master cycles. The internal phase is low for the first F cycles after `enable` rises and high for the next F cycles, and it alternates from then on. `bclk` is that phase XOR `cfg_bclk_inv`, and a new serial bit starts every 2F cycles, each time the phase returns low.
- R3: With `cfg_long` = 0, a frame is `cfg_slots` slots of 32 bits each, and `cfg_slots` ranges from 2 to 32. Slot 0 begins with the first bit after enabling, and the slot sequence repeats with no gap.
- R4: With `cfg_long` = 1, a frame is 384 slots and `cfg_slots` is ignored. Slot s uses mask bit s mod 32.
- R5: A slot's 32-bit sample is sent MSB first with a one-bit delay. Its bit 31 appears in the slot's bit position 1, and its bit 0 appears in bit position 0 of the following slot. The first bit after enabling is 0.
- R6: Frame sync width: with `cfg_fs_slot` = 0 the sync is active for bit 0 of slot 0 only, and with `cfg_fs_slot` = 1 it is active for all 32 bits of slot 0.
- R7: `fsync` is the active-high sync XOR `cfg_fs_inv`.
- R8: When bit s of `cfg_slot_en` is 0, the 32 data bits that belong to slot s are 0 on every pin. No pending sample is taken, so a sample written earlier goes to the next enabled slot.
- R9: All pins share timing. A write with `wr_valid` = 1 stores `wr_data` as the pending sample of pin `wr_pin`, and each pin sends only its own samples.
- R10: `last_slot` is high for exactly one master cycle. That cycle is the first one of bit 0 of the last slot of each frame (slot `cfg_slots`-1, or slot 383 in long mode).
- R11: If an enabled slot starts while a pin has no pending sample, that pin sends zeros for the slot and `underrun` goes to 1 in the same cycle. It stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the transmitter; low holds the serial side idle |
| cfg_div | input | 12 | Bit-clock half-period length minus one, in master cycles |
| cfg_slots | input | 6 | Slots per frame (2 to 32) in normal mode |
| cfg_long | input | 1 | Select the 384-slot frame |
| cfg_slot_en | input | 32 | Per-slot enable mask |
| cfg_bclk_inv | input | 1 | Invert the bit clock |
| cfg_fs_slot | input | 1 | Frame sync one slot wide (1) or one bit wide (0) |
| cfg_fs_inv | input | 1 | Invert the frame sync |
| wr_valid | input | 1 | Sample write strobe |
| wr_pin | input | 1 | Pin that receives the written sample |
| wr_data | input | 32 | Sample word |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 2 | Serial data, one bit per pin |
| last_slot | output | 1 | Start-of-last-slot event |
| underrun | output | 1 | Sticky missing-sample flag |

## Verification
The bench works out each pin's level, the clock phase and the sync in every master cycle from the cycle count alone. It covers frames of 3, 4 and 32 slots, the 384-slot frame, and divide factors of 1, 2, 3 and 4096. A design that lost the one-bit delay, or that sent the LSB first, would show wrong bits in every slot. One that took the pending sample during a masked slot would put data into a slot that must be silent. It would then also underrun on the next enabled slot.

A deliberately missing sample shows whether the underrun flag is set at the right slot and stays set. A design that counted the slot length off by one would put the last-slot event and the frame wrap in the wrong place. Testing both sync widths with both polarities catches a sync that is misplaced or inverted.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
   localparam int SLOT_BITS  = 32;
   localparam int MAX_SLOTS  = 32;
   localparam int LONG_SLOTS = 384;
   localparam int BIT_W      = $clog2(SLOT_BITS);

   // per-bit control broadcast from the sequencer to every lane
   typedef struct packed {
      logic tick;     // a new serial bit starts this cycle
      logic load;     // the new bit is bit 0 of a slot
      logic slot_on;  // that slot is enabled by the mask
   } lane_ctl_t;
endpackage

// File: rtl/tdm_bclk_div.sv
module tdm_bclk_div #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             ph,
   output logic             bit_tick
);
   logic [DIV_W-1:0] hcnt;
   logic             half_end;

   assign half_end = en && (hcnt == div);
   assign bit_tick = half_end && ph;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         hcnt <= '0;
         ph   <= 1'b0;
      end else if (half_end) begin
         hcnt <= '0;
         ph   <= ~ph;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hcnt != div) |=> (!en || $stable(ph))); // R2
   AST_TICK_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> !ph); // R2
endmodule

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq
   import tdm_tx_pkg::*;
#(
   parameter bit LONG_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        bit_tick,
   input  logic [5:0]  cfg_slots,
   input  logic        cfg_long,
   input  logic [31:0] cfg_mask,
   input  logic        cfg_fs_slot,
   output lane_ctl_t   ctl,
   output logic        fs_q,
   output logic        last_q
);
   localparam int SW = LONG_EN ? $clog2(LONG_SLOTS) : $clog2(MAX_SLOTS);

   logic [BIT_W-1:0] bit_q, nb;
   logic [SW-1:0]    slot_q, ns, last_idx, wrap_slot;
   logic             run_q, slot_end;

   generate
      if (LONG_EN) begin : g_long
         assign last_idx = cfg_long ? SW'(LONG_SLOTS - 1) : SW'(cfg_slots) - SW'(1);
      end else begin : g_short
         assign last_idx = SW'(cfg_slots) - SW'(1);
      end
   endgenerate

   always_comb begin
      slot_end    = (bit_q == BIT_W'(SLOT_BITS - 1)) || !run_q;
      wrap_slot   = (!run_q || slot_q == last_idx) ? '0 : slot_q + 1'b1;
      nb          = slot_end ? '0 : bit_q + 1'b1;
      ns          = slot_end ? wrap_slot : slot_q;
      ctl.tick    = bit_tick;
      ctl.load    = bit_tick && slot_end;
      ctl.slot_on = cfg_mask[ns[4:0]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         bit_q  <= '1;
         slot_q <= '0;
         run_q  <= 1'b0;
         fs_q   <= 1'b0;
         last_q <= 1'b0;
      end else begin
         last_q <= bit_tick && slot_end && (wrap_slot == last_idx);
         if (bit_tick) begin
            run_q  <= 1'b1;
            bit_q  <= nb;
            slot_q <= ns;
            fs_q   <= (ns == '0) && (cfg_fs_slot || nb == '0);
         end
      end
   end

   AST_LAST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      last_q |=> !last_q); // R10
   AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (slot_q <= last_idx)); // R3
   AST_FS_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_q && !cfg_fs_slot) |-> (bit_q == '0 && slot_q == '0)); // R6
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
   import tdm_tx_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  lane_ctl_t            ctl,
   input  logic                 wr_en,
   input  logic [SLOT_BITS-1:0] wr_data,
   output logic                 sd,
   output logic                 underrun
);
   logic [SLOT_BITS-1:0] buf_q, sh_q;
   logic                 full_q, take;

   assign take = ctl.load && ctl.slot_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
      end else if (wr_en) begin
         buf_q  <= wr_data;
         full_q <= 1'b1;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         sh_q <= '0;
         sd   <= 1'b0;
      end else if (ctl.tick) begin
         sd   <= sh_q[SLOT_BITS-1];
         if (ctl.load) sh_q <= (take && full_q) ? buf_q : '0;
         else          sh_q <= sh_q << 1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               underrun <= 1'b0;
      else if (take && !full_q) underrun <= 1'b1;
   end

   AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun); // R11
   AST_MASKED_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.load && !ctl.slot_on && full_q) |=> full_q); // R8
   AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (take && full_q && !wr_en) |=> !full_q); // R9
endmodule

// File: rtl/tdm_audio_tx.sv
module tdm_audio_tx
   import tdm_tx_pkg::*;
#(
   parameter int N_PINS  = 2,
   parameter int DIV_W   = 12,
   parameter bit LONG_EN = 1'b1,
   localparam int PIN_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic [DIV_W-1:0]     cfg_div,
   input  logic [5:0]           cfg_slots,
   input  logic                 cfg_long,
   input  logic [31:0]          cfg_slot_en,
   input  logic                 cfg_bclk_inv,
   input  logic                 cfg_fs_slot,
   input  logic                 cfg_fs_inv,
   input  logic                 wr_valid,
   input  logic [PIN_W-1:0]     wr_pin,
   input  logic [SLOT_BITS-1:0] wr_data,
   output logic                 bclk,
   output logic                 fsync,
   output logic [N_PINS-1:0]    sdata,
   output logic                 last_slot,
   output logic                 underrun
);
   initial begin
      assert (N_PINS >= 1 && N_PINS <= 16) else $error("N_PINS out of range");
      assert (DIV_W >= 1 && DIV_W <= 16) else $error("DIV_W out of range");
   end

   logic              ph, bit_tick, fs_q;
   lane_ctl_t         ctl;
   logic [N_PINS-1:0] urun;

   tdm_bclk_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(enable), .div(cfg_div),
      .ph(ph), .bit_tick(bit_tick));

   tdm_frame_seq #(.LONG_EN(LONG_EN)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(enable), .bit_tick(bit_tick),
      .cfg_slots(cfg_slots), .cfg_long(cfg_long), .cfg_mask(cfg_slot_en),
      .cfg_fs_slot(cfg_fs_slot), .ctl(ctl), .fs_q(fs_q), .last_q(last_slot));

   for (genvar i = 0; i < N_PINS; i++) begin : g_lane
      tdm_tx_lane u_lane (
         .clk(clk), .rst_n(rst_n), .en(enable), .ctl(ctl),
         .wr_en(wr_valid && wr_pin == PIN_W'(i)), .wr_data(wr_data),
         .sd(sdata[i]), .underrun(urun[i]));
   end

   assign bclk     = ph ^ cfg_bclk_inv;
   assign fsync    = fs_q ^ cfg_fs_inv;
   assign underrun = |urun;
endmodule

// File: tb/tdm_audio_tx_test.sv
module tdm_audio_tx_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0, enable = 1'b0;
   logic [11:0] cfg_div = '0;
   logic [5:0]  cfg_slots = 6'd2;
   logic        cfg_long = 1'b0, cfg_bclk_inv = 1'b0, cfg_fs_slot = 1'b0, cfg_fs_inv = 1'b0;
   logic [31:0] cfg_slot_en = '1;
   logic        wr_valid = 1'b0;
   logic [0:0]  wr_pin = '0;
   logic [31:0] wr_data = '0;
   logic        bclk, fsync, last_slot, underrun;
   logic [1:0]  sdata;

   int checks = 0, errors = 0, cyc = 0;
   int cF, cN, cskip;
   logic [31:0] cmask;

   always #10 clk = ~clk;

   tdm_audio_tx uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
      .cfg_slots(cfg_slots), .cfg_long(cfg_long), .cfg_slot_en(cfg_slot_en),
      .cfg_bclk_inv(cfg_bclk_inv), .cfg_fs_slot(cfg_fs_slot), .cfg_fs_inv(cfg_fs_inv),
      .wr_valid(wr_valid), .wr_pin(wr_pin), .wr_data(wr_data),
      .bclk(bclk), .fsync(fsync), .sdata(sdata), .last_slot(last_slot), .underrun(underrun));

   task automatic chk(input logic act, input logic exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s cyc %0d: actual %b expected %b", tag, what, cyc, act, exp);
      end
   endtask

   function automatic bit slot_on(int g);
      int s = g % cN;
      return cmask[s % 32];
   endfunction

   function automatic int next_on(int g);
      int t = g + 1;
      while (!slot_on(t)) t++;
      return t;
   endfunction

   function automatic logic [31:0] wd(int pin, int g);
      return 32'h5A00_0000 ^ (32'(pin) * 32'h0123_4567) ^ (32'(g) * 32'h9E37_79B1);
   endfunction

   function automatic logic [31:0] sent(int pin, int g);
      if (g < 0 || !slot_on(g) || g == cskip) return 32'h0;
      return wd(pin, g);
   endfunction

   task automatic put(int pin, logic [31:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_pin = 1'(pin); wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic run_cfg(int div, int slots, bit lng, logic [31:0] mask, bit binv,
                          bit fsslot, bit fsinv, int skip, int nbits, string ltag);
      int t0, limit;
      cF = div + 1; cN = lng ? 384 : slots; cskip = skip; cmask = mask;
      @(negedge clk);
      rst_n = 1'b0; enable = 1'b0; wr_valid = 1'b0;
      cfg_div = 12'(div); cfg_slots = 6'(slots); cfg_long = lng; cfg_slot_en = mask;
      cfg_bclk_inv = binv; cfg_fs_slot = fsslot; cfg_fs_inv = fsinv;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cyc = 0;
      // R1: idle state after reset
      chk(bclk, binv, "R1", "idle bclk");
      chk(fsync, fsinv, "R1", "idle fsync");
      chk(sdata[0], 1'b0, "R1", "idle sdata0");
      chk(sdata[1], 1'b0, "R1", "idle sdata1");
      chk(last_slot, 1'b0, "R1", "idle last_slot");
      chk(underrun, 1'b0, "R1", "idle underrun");
      t0 = next_on(-1);
      if (t0 != cskip) begin
         put(0, wd(0, t0));
         put(1, wd(1, t0));
      end
      @(negedge clk);
      enable = 1'b1;
      limit = 2 * cF * (nbits + 1);
      while (cyc < limit) begin
         int k, p, b, gw, bp;
         logic fs_e, last_e, ur_e;
         string dtag;
         @(posedge clk);
         cyc++;
         @(negedge clk);
         k = (cyc >= 2 * cF) ? cyc / (2 * cF) - 1 : -1;
         chk(bclk, 1'((cyc / cF) % 2) ^ binv, "R2", "bclk");
         if (k < 0) begin
            fs_e = 1'b0; last_e = 1'b0;
            chk(sdata[0], 1'b0, "R5", "pre-start sdata0");
            chk(sdata[1], 1'b0, "R5", "pre-start sdata1");
         end else begin
            p = k % (cN * 32);
            b = k % 32;
            fs_e = fsslot ? (p < 32) : (p == 0);
            last_e = (cyc % (2 * cF) == 0) && (p == (cN - 1) * 32);
            gw = (b != 0) ? k / 32 : k / 32 - 1;
            bp = (b != 0) ? 32 - b : 0;
            for (int pin = 0; pin < 2; pin++) begin
               logic [31:0] w = sent(pin, gw);
               if (gw >= 0 && !slot_on(gw)) dtag = "R8";
               else if (gw >= 0 && gw == cskip) dtag = "R11";
               else dtag = (pin == 1) ? "R9" : "R5";
               chk(sdata[pin], w[bp], dtag, pin == 1 ? "sdata1" : "sdata0");
            end
         end
         chk(fsync, fs_e ^ fsinv, fsinv ? "R7" : "R6", "fsync");
         chk(last_slot, last_e, ltag, "last_slot event");
         ur_e = (cskip >= 0) && (k >= cskip * 32);
         chk(underrun, ur_e, "R11", "underrun flag");
         wr_valid = 1'b0;
         if (k >= 0 && k % 32 == 8 && cyc % (2 * cF) < 2) begin
            int t = next_on(k / 32);
            if (t != cskip) begin
               int pin = cyc % (2 * cF);
               wr_valid = 1'b1; wr_pin = 1'(pin); wr_data = wd(pin, t);
            end
         end
      end
      @(negedge clk);
      enable = 1'b0; wr_valid = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R8 slot 2 masked, R10 event in a 4-slot frame, divide by 1
      run_cfg(0, 4, 1'b0, 32'h0000_000B, 1'b0, 1'b0, 1'b0, -1, 257, "R10");
      // R7 inverted sync, R6 slot-wide sync, R11 missing sample for slot 4, divide by 3
      run_cfg(2, 3, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 4, 194, "R10");
      // R3 full 32-slot frame with alternate slots masked
      run_cfg(1, 32, 1'b0, 32'h5555_5555, 1'b0, 1'b0, 1'b0, -1, 1064, "R3");
      // R4 384-slot frame, slot count input set to 5 and ignored
      run_cfg(0, 5, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, -1, 12328, "R4");
      // R2 largest divide factor 4096
      run_cfg(4095, 2, 1'b0, 32'h0000_0003, 1'b0, 1'b1, 1'b0, -1, 2, "R10");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule